// File: doc/BRIEF.md
# Rank-Accumulating Sparse Vector Scaler

This block performs the final stage of a low-rank approximated matrix-vector product that is shared by several independent inputs. For every rank of the approximation, a shared feed supplies the non-pruned tiles of that rank's right vector. Each tile arrives together with one scaled scalar per input lane. Every lane multiplies its scalar element-wise into the tile and adds the products into its own accumulator. The accumulator is split into one bank per tile. Tiles that were pruned are never presented to the block, so they are never read or multiplied.

The upstream logic marks the final beat of a time step. The block then finishes any update still in flight. It streams every lane's result vector out one tile per beat on a valid/ready interface, and each beat is tagged with its lane and tile index. Input is refused for the whole readout. On the last accepted output beat every accumulator returns to zero, so the next time step starts clean.

Each bank is updated by a read-modify-write that spans two cycles. A parameter chooses how a hazard between back-to-back updates of the same tile is resolved. The forwarding variant passes the newer sum to the second update. The stalling variant holds the input for one cycle.

Top module: `rsv_scaler`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Lane j's scalar is the signed field in_scal[j*SW +: SW], and element e of the tile is the signed field in_vec[e*DW +: DW]. Each result element out_data[e*ACC_W +: ACC_W] equals the sum, over all beats of the time step that carried that tile, of scalar times element, wrapped to ACC_W bits.
- R3: A tile index that no beat of a time step carried reads out as all zeros.
- R4: Beats that carry the same tile index on consecutive cycles all contribute to the result. No update is lost.
- R5: in_ready is 0 from the cycle after a beat with in_last is accepted until the final output beat is accepted. It is 1 again in the cycle after that final beat.
- R6: Readout delivers exactly LANES*TILES beats, one per handshake. The order is lane 0 first, and tiles ascend from 0 within each lane.
- R7: While out_valid is 1 and out_ready is 0, the output beat (valid, lane, tile, data) holds unchanged into the next cycle.
- R8: The accumulators are zero when a new time step begins, so no result depends on earlier time steps.
- R9: Beats presented with in_valid while in_ready is 0 are ignored and change no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block accepts an input beat |
| in_last | input | 1 | Beat is the final one of the time step |
| in_tile | input | clog2(TILES) | Index of the non-pruned tile carried by the beat |
| in_scal | input | LANES*SW | One signed scaled scalar per lane |
| in_vec | input | TW*DW | Signed elements of the shared tile |
| out_valid | output | 1 | Output tile valid |
| out_ready | input | 1 | Consumer accepts the output tile |
| out_lane | output | clog2(LANES) | Lane of the output tile |
| out_tile | output | clog2(TILES) | Tile index of the output tile |
| out_data | output | TW*ACC_W | Accumulated signed elements of the tile |

## Verification
The hardest case to reach from the ports is a read-modify-write hazard: one tile index must be presented on back-to-back cycles, so that the second bank read lands before the first write. The stimulus brings this about with a dedicated time step that sends the same tile several times in a row with no idle cycle between beats. Its results are then compared against a sum the bench computes itself. A second hard case is input arriving during readout under random output backpressure. The bench holds a junk final beat valid for the whole readout. It then checks that the following time step, built from extreme signed values, gives exactly its own sums.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

   typedef enum logic [1:0] {
      SEQ_ACC   = 2'd0,
      SEQ_FLUSH = 2'd1,
      SEQ_READ  = 2'd2
   } seq_state_e;

   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/rsv_tile_mult.sv
module rsv_tile_mult #(
   parameter int TW = 2,
   parameter int SW = 8,
   parameter int DW = 8
) (
   input  logic [SW-1:0]         scal,
   input  logic [TW*DW-1:0]      vec,
   output logic [TW*(SW+DW)-1:0] prod
);
   localparam int PW = SW + DW;

   logic signed [PW-1:0] scal_ext;
   assign scal_ext = PW'($signed(scal));

   for (genvar e = 0; e < TW; e++) begin : g_elem
      logic signed [PW-1:0] elem_ext;
      assign elem_ext = PW'($signed(vec[e*DW +: DW]));
      assign prod[e*PW +: PW] = scal_ext * elem_ext;
   end

endmodule

// File: rtl/rsv_acc_banks.sv
module rsv_acc_banks #(
   parameter int TILES   = 4,
   parameter int TW      = 2,
   parameter int PW      = 16,
   parameter int ACC_W   = 20,
   parameter int FORWARD = 1,
   localparam int TIW    = rsv_pkg::idx_w(TILES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                clr,
   input  logic                in_fire,
   input  logic [TIW-1:0]      in_tile,
   input  logic [TW*PW-1:0]    in_prod,
   input  logic [TIW-1:0]      rd_tile,
   output logic [TW*ACC_W-1:0] rd_data,
   output logic                hazard
);
   logic                p_vld;
   logic [TIW-1:0]      p_tile;
   logic [TW*PW-1:0]    p_prod;
   logic [TW*ACC_W-1:0] base_q;
   logic [TW*ACC_W-1:0] sum;
   logic [TW*ACC_W-1:0] bank_q [TILES];

   assign hazard = p_vld && (p_tile == in_tile);

   for (genvar e = 0; e < TW; e++) begin : g_add
      assign sum[e*ACC_W +: ACC_W] =
         base_q[e*ACC_W +: ACC_W] + ACC_W'($signed(p_prod[e*PW +: PW]));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p_vld  <= 1'b0;
         p_tile <= '0;
         p_prod <= '0;
      end else begin
         p_vld <= in_fire;
         if (in_fire) begin
            p_tile <= in_tile;
            p_prod <= in_prod;
         end
      end
   end

   if (FORWARD != 0) begin : g_fwd
      always_ff @(posedge clk) begin
         if (!rst_n)
            base_q <= '0;
         else if (in_fire)
            base_q <= hazard ? sum : bank_q[in_tile];
      end
   end else begin : g_plain
      always_ff @(posedge clk) begin
         if (!rst_n)
            base_q <= '0;
         else if (in_fire)
            base_q <= bank_q[in_tile];
      end
   end

   for (genvar t = 0; t < TILES; t++) begin : g_bank
      always_ff @(posedge clk) begin
         if (!rst_n)
            bank_q[t] <= '0;
         else if (clr)
            bank_q[t] <= '0;
         else if (p_vld && (p_tile == TIW'(t)))
            bank_q[t] <= sum;
      end
   end

   assign rd_data = bank_q[rd_tile];

endmodule

// File: rtl/rsv_sequencer.sv
module rsv_sequencer #(
   parameter int LANES = 2,
   parameter int TILES = 4,
   parameter int STALL = 0,
   localparam int LW   = rsv_pkg::idx_w(LANES),
   localparam int TIW  = rsv_pkg::idx_w(TILES)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   input  logic           in_last,
   input  logic           hazard,
   output logic           in_ready,
   output logic           in_fire,
   output logic           out_valid,
   input  logic           out_ready,
   output logic [LW-1:0]  rd_lane,
   output logic [TIW-1:0] rd_tile,
   output logic           clr
);
   import rsv_pkg::*;

   seq_state_e     state_q;
   logic [LW-1:0]  lane_q;
   logic [TIW-1:0] tile_q;
   logic           tile_end;
   logic           last_pos;

   assign tile_end  = (tile_q == TIW'(TILES - 1));
   assign last_pos  = tile_end && (lane_q == LW'(LANES - 1));
   assign in_ready  = (state_q == SEQ_ACC) && !((STALL != 0) && hazard);
   assign in_fire   = in_valid && in_ready;
   assign out_valid = (state_q == SEQ_READ);
   assign clr       = out_valid && out_ready && last_pos;
   assign rd_lane   = lane_q;
   assign rd_tile   = tile_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_ACC;
         lane_q  <= '0;
         tile_q  <= '0;
      end else begin
         case (state_q)
            SEQ_ACC: begin
               if (in_fire && in_last)
                  state_q <= SEQ_FLUSH;
            end
            SEQ_FLUSH: begin
               state_q <= SEQ_READ;
               lane_q  <= '0;
               tile_q  <= '0;
            end
            SEQ_READ: begin
               if (out_ready) begin
                  if (last_pos) begin
                     state_q <= SEQ_ACC;
                     lane_q  <= '0;
                     tile_q  <= '0;
                  end else if (tile_end) begin
                     tile_q <= '0;
                     lane_q <= lane_q + LW'(1);
                  end else begin
                     tile_q <= tile_q + TIW'(1);
                  end
               end
            end
            default: state_q <= SEQ_ACC;
         endcase
      end
   end

endmodule

// File: rtl/rsv_scaler.sv
module rsv_scaler #(
   parameter int LANES       = 2,
   parameter int TILES       = 4,
   parameter int TW          = 2,
   parameter int SW          = 8,
   parameter int DW          = 8,
   parameter int ACC_W       = 20,
   parameter int HAZARD_MODE = 0,
   localparam int LW         = rsv_pkg::idx_w(LANES),
   localparam int TIW        = rsv_pkg::idx_w(TILES)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   output logic                  in_ready,
   input  logic                  in_last,
   input  logic [TIW-1:0]        in_tile,
   input  logic [LANES*SW-1:0]   in_scal,
   input  logic [TW*DW-1:0]      in_vec,
   output logic                  out_valid,
   input  logic                  out_ready,
   output logic [LW-1:0]         out_lane,
   output logic [TIW-1:0]        out_tile,
   output logic [TW*ACC_W-1:0]   out_data
);
   localparam int PW = SW + DW;

   if (LANES < 1) begin : g_bad_lanes
      $error("rsv_scaler: LANES must be at least 1");
   end
   if (TILES < 1) begin : g_bad_tiles
      $error("rsv_scaler: TILES must be at least 1");
   end
   if (TW < 1) begin : g_bad_tw
      $error("rsv_scaler: TW must be at least 1");
   end
   if (ACC_W < PW) begin : g_bad_acc
      $error("rsv_scaler: ACC_W must hold a full product");
   end
   if (HAZARD_MODE > 1) begin : g_bad_mode
      $error("rsv_scaler: HAZARD_MODE is 0 (forward) or 1 (stall)");
   end

   logic                 in_fire;
   logic                 clr;
   logic                 hazard;
   logic [LANES-1:0]     hz_vec;
   logic [TW*ACC_W-1:0]  lane_rd [LANES];

   assign hazard = |hz_vec;

   rsv_sequencer #(
      .LANES (LANES),
      .TILES (TILES),
      .STALL (HAZARD_MODE)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_last   (in_last),
      .hazard    (hazard),
      .in_ready  (in_ready),
      .in_fire   (in_fire),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .rd_lane   (out_lane),
      .rd_tile   (out_tile),
      .clr       (clr)
   );

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [TW*PW-1:0] prod;

      rsv_tile_mult #(
         .TW (TW),
         .SW (SW),
         .DW (DW)
      ) u_mult (
         .scal (in_scal[j*SW +: SW]),
         .vec  (in_vec),
         .prod (prod)
      );

      rsv_acc_banks #(
         .TILES   (TILES),
         .TW      (TW),
         .PW      (PW),
         .ACC_W   (ACC_W),
         .FORWARD ((HAZARD_MODE == 0) ? 1 : 0)
      ) u_banks (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (clr),
         .in_fire (in_fire),
         .in_tile (in_tile),
         .in_prod (prod),
         .rd_tile (out_tile),
         .rd_data (lane_rd[j]),
         .hazard  (hz_vec[j])
      );
   end

   always_comb begin
      out_data = '0;
      for (int j = 0; j < LANES; j++) begin
         if (out_lane == LW'(j))
            out_data = lane_rd[j];
      end
   end

endmodule

// File: rtl/rsv_scaler_chk.sv
module rsv_scaler_chk #(
   parameter int LANES = 2,
   parameter int TILES = 4,
   parameter int TW    = 2,
   parameter int ACC_W = 20,
   localparam int LW   = rsv_pkg::idx_w(LANES),
   localparam int TIW  = rsv_pkg::idx_w(TILES)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                in_ready,
   input logic                in_last,
   input logic [TIW-1:0]      in_tile,
   input logic                out_valid,
   input logic                out_ready,
   input logic [LW-1:0]       out_lane,
   input logic [TIW-1:0]      out_tile,
   input logic [TW*ACC_W-1:0] out_data
);
   logic hs_last;
   assign hs_last = out_valid && out_ready &&
                    (int'(out_lane) == LANES - 1) && (int'(out_tile) == TILES - 1);

   AST_TILE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |-> (int'(in_tile) < TILES));  // R2

   AST_LOCK_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_last) |=> !in_ready);  // R5

   AST_NO_INPUT_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);  // R5

   AST_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
      hs_last |=> (in_ready && !out_valid));  // R5

   AST_READ_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && !hs_last) |=>
         (out_valid && (int'(out_lane) * TILES + int'(out_tile) ==
                        $past(int'(out_lane) * TILES + int'(out_tile)) + 1)));  // R6

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=>
         (out_valid && $stable(out_lane) && $stable(out_tile) && $stable(out_data)));  // R7

endmodule

bind rsv_scaler rsv_scaler_chk #(
   .LANES (LANES),
   .TILES (TILES),
   .TW    (TW),
   .ACC_W (ACC_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_last   (in_last),
   .in_tile   (in_tile),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_lane  (out_lane),
   .out_tile  (out_tile),
   .out_data  (out_data)
);

// File: tb/tb_rsv_scaler.sv
module tb_rsv_scaler;
   localparam int CLK_PERIOD = 10;
   localparam int LANES = 2;
   localparam int TILES = 4;
   localparam int TW    = 2;
   localparam int SW    = 8;
   localparam int DW    = 8;
   localparam int ACC_W = 20;
   localparam int LW    = 1;
   localparam int TIW   = 2;

   logic                clk = 1'b0;
   logic                rst_n;
   logic                in_valid;
   logic                in_ready;
   logic                in_last;
   logic [TIW-1:0]      in_tile;
   logic [LANES*SW-1:0] in_scal;
   logic [TW*DW-1:0]    in_vec;
   logic                out_valid;
   logic                out_ready;
   logic [LW-1:0]       out_lane;
   logic [TIW-1:0]      out_tile;
   logic [TW*ACC_W-1:0] out_data;

   rsv_scaler #(
      .LANES (LANES), .TILES (TILES), .TW (TW),
      .SW (SW), .DW (DW), .ACC_W (ACC_W), .HAZARD_MODE (0)
   ) dut (
      .clk (clk), .rst_n (rst_n),
      .in_valid (in_valid), .in_ready (in_ready), .in_last (in_last),
      .in_tile (in_tile), .in_scal (in_scal), .in_vec (in_vec),
      .out_valid (out_valid), .out_ready (out_ready),
      .out_lane (out_lane), .out_tile (out_tile), .out_data (out_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      int                  lane;
      int                  tile;
      logic [TW*ACC_W-1:0] data;
      string               tag;
   } item_t;

   item_t sbq[$];
   int    model [LANES][TILES][TW];
   bit    touched [TILES];
   bit    bp_mode;
   int    n_chk;
   int    n_fail;

   bit                  hold_pend;
   logic [LW-1:0]       h_lane;
   logic [TIW-1:0]      h_tile;
   logic [TW*ACC_W-1:0] h_data;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic clear_model();
      for (int j = 0; j < LANES; j++)
         for (int t = 0; t < TILES; t++)
            for (int e = 0; e < TW; e++)
               model[j][t][e] = 0;
      for (int t = 0; t < TILES; t++) touched[t] = 1'b0;
   endtask

   // Driver: presents one beat, updates the model, queues expected tiles at the end of a step
   task automatic send(input int tile, input logic [LANES*SW-1:0] sc,
                       input logic [TW*DW-1:0] v, input bit last, input string tag);
      bit rdy;
      for (int j = 0; j < LANES; j++)
         for (int e = 0; e < TW; e++)
            model[j][tile][e] += int'($signed(sc[j*SW +: SW])) * int'($signed(v[e*DW +: DW]));
      touched[tile] = 1'b1;
      in_valid = 1'b1;
      in_last  = last;
      in_tile  = TIW'(tile);
      in_scal  = sc;
      in_vec   = v;
      forever begin
         @(negedge clk);
         rdy = in_ready;
         @(posedge clk);
         #1;
         if (rdy) break;
      end
      in_valid = 1'b0;
      in_last  = 1'b0;
      if (last) begin
         for (int j = 0; j < LANES; j++) begin
            for (int t = 0; t < TILES; t++) begin
               item_t it;
               it.lane = j;
               it.tile = t;
               for (int e = 0; e < TW; e++)
                  it.data[e*ACC_W +: ACC_W] = ACC_W'(model[j][t][e]);
               it.tag = touched[t] ? tag : "R3";
               sbq.push_back(it);
            end
         end
         clear_model();
         @(negedge clk);
         check(in_ready == 1'b0, "R5", "in_ready after final beat", 64'(in_ready), 64'd0);
         @(posedge clk);
         #1;
      end
   endtask

   // Holds a junk final beat valid for the whole readout (R9)
   task automatic junk();
      in_valid = 1'b1;
      in_last  = 1'b1;
      in_tile  = TIW'($urandom_range(TILES - 1));
      in_scal  = LANES*SW'($urandom);
      in_vec   = TW*DW'($urandom);
      forever begin
         @(posedge clk);
         #1;
         if (in_ready) break;
      end
      in_valid = 1'b0;
      in_last  = 1'b0;
   endtask

   task automatic wait_drain();
      while (sbq.size() != 0) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      check(in_ready == 1'b1 && out_valid == 1'b0, "R5", "ready/valid after readout",
            64'({in_ready, out_valid}), 64'b10);
      @(posedge clk);
      #1;
   endtask

   task automatic rand_step(input int beats, input string tag);
      for (int b = 0; b < beats; b++)
         send($urandom_range(TILES - 1), LANES*SW'($urandom), TW*DW'($urandom),
              b == beats - 1, tag);
   endtask

   // Monitor: pops expected tiles on every handshake, watches hold under backpressure
   always @(negedge clk) begin
      if (rst_n) begin
         if (hold_pend)
            check(out_valid && out_lane == h_lane && out_tile == h_tile && out_data == h_data,
                  "R7", "beat held under backpressure", 64'(out_data), 64'(h_data));
         hold_pend = out_valid && !out_ready;
         h_lane    = out_lane;
         h_tile    = out_tile;
         h_data    = out_data;
         if (out_valid && out_ready) begin
            if (sbq.size() == 0) begin
               check(1'b0, "R6", "unexpected output beat", 64'(out_tile), 64'd0);
            end else begin
               item_t it;
               it = sbq.pop_front();
               check(int'(out_lane) == it.lane && int'(out_tile) == it.tile, "R6",
                     "lane/tile order", 64'({out_lane, out_tile}),
                     64'({LW'(it.lane), TIW'(it.tile)}));
               check(out_data == it.data, it.tag, "tile data", 64'(out_data), 64'(it.data));
            end
         end
      end
   end

   initial begin
      out_ready = 1'b0;
      forever begin
         @(posedge clk);
         #1;
         out_ready = bp_mode ? ($urandom_range(2) != 0) : 1'b1;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0;
      in_tile = '0; in_scal = '0; in_vec = '0;
      bp_mode = 1'b0; hold_pend = 1'b0;
      n_chk = 0; n_fail = 0;
      clear_model();
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
      check(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'd1);
      @(posedge clk);
      #1;

      // R2/R3: three ranks, tile 3 pruned throughout
      send(0, LANES*SW'($urandom), TW*DW'($urandom), 1'b0, "R2");
      send(2, LANES*SW'($urandom), TW*DW'($urandom), 1'b0, "R2");
      send(1, LANES*SW'($urandom), TW*DW'($urandom), 1'b0, "R2");
      send(0, LANES*SW'($urandom), TW*DW'($urandom), 1'b0, "R2");
      send(2, LANES*SW'($urandom), TW*DW'($urandom), 1'b1, "R2");
      wait_drain();

      // R4: same tile on back-to-back cycles
      for (int k = 0; k < 5; k++)
         send(1, LANES*SW'($urandom), TW*DW'($urandom), 1'b0, "R4");
      send(3, LANES*SW'($urandom), TW*DW'($urandom), 1'b0, "R4");
      send(3, LANES*SW'($urandom), TW*DW'($urandom), 1'b1, "R4");
      wait_drain();

      // R9: junk beat held valid during a backpressured readout
      bp_mode = 1'b1;
      send(0, LANES*SW'($urandom), TW*DW'($urandom), 1'b0, "R9");
      send(2, LANES*SW'($urandom), TW*DW'($urandom), 1'b1, "R9");
      junk();
      wait_drain();

      // R8: fresh step with signed extremes must not carry earlier sums
      send(0, {8'h80, 8'h80}, {8'h80, 8'h80}, 1'b0, "R8");
      send(0, {8'h7f, 8'h80}, {8'h80, 8'h7f}, 1'b0, "R8");
      send(2, {8'h80, 8'h7f}, {8'h7f, 8'h80}, 1'b1, "R8");
      wait_drain();

      for (int s = 0; s < 4; s++) begin
         bp_mode = s[0];
         rand_step(3 + s * 2, "R2");
         wait_drain();
      end

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule